// File: doc/BRIEF.md
# Multi-Phit Flit Link Serializer/Deserializer

This block moves wide flits across a narrow point-to-point link. Each flit is 70 bits wide. The low 64 bits are the data word and the top 6 bits are a control field. On the transmit side a whole flit is accepted and sent as five consecutive 14-bit phits, least-significant slice first. A start marker travels alongside the first phit. On the receive side the start marker sets the phit position. The following phits are gathered and the rebuilt flit is presented for one cycle once the fifth phit has arrived.

The control field frames request packets. A packet is a read or a write request, and it is either short (one data word) or long (eight data words). Every flit carries exactly one data word. The receiver follows the framing flits and raises an error alongside any tail flit whose packet did not deliver the word count that its head declared.

The block runs on the link clock. One flit every five cycles matches the five-to-one ratio between the phit rate and the flit rate of the switch core. Differential signalling and clock-domain crossing are outside the block.

Top module: `flit_link_serdes`

## Requirements
- R1: After reset `tx_ready_o` is 1, and `tx_phit_vld_o`, `tx_phit_sop_o`, `rx_flit_vld_o` and `rx_len_err_o` are all 0.
- R2: A flit is taken in a cycle with `tx_valid_i` and `tx_ready_o` both high. In the five following cycles `tx_phit_vld_o` is 1, and in the k-th of those cycles (k = 0..4) `tx_phit_o` carries flit bits [14k+13:14k].
- R3: `tx_phit_sop_o` is 1 only together with phit 0 of a flit.
- R4: `tx_ready_o` is 1 while the transmitter is idle and in the cycle that carries phit 4, and 0 otherwise. A flit offered while `tx_ready_o` is 0 is not taken, and the phits in flight are unchanged. Flits offered back to back leave at one flit every five cycles.
- R5: A valid phit with `rx_phit_sop_i` high fills slot 0. Each later valid phit fills the next slot, and cycles with `rx_phit_vld_i` low are skipped. In the cycle after slot 4 is filled, `rx_flit_o` shows the slots concatenated (slot 0 in the low bits) and `rx_flit_vld_o` is high for that one cycle.
- R6: A valid phit without a start marker is dropped while no flit is being gathered. A start marker in the middle of a flit discards the partial flit and starts again at slot 0.
- R7: Control field flit[69:64]: bit 64 = head, bit 65 = tail, bit 66 = write (1) or read (0), bit 67 = long (8 words) or short (1 word). Bits 68 and 69 are carried through unchanged. A single-flit packet has head and tail both set.
- R8: `rx_len_err_o` is 1 with a tail flit's `rx_flit_vld_o` when the count of flits from the latest head through this tail, both counted, differs from 1 for a short packet or from 8 for a long one. The read/write bit has no effect on this check. A new head restarts the count.
- R9: A tail that arrives with no packet open raises `rx_len_err_o`. A flit with neither head nor tail that arrives with no packet open is ignored and opens nothing.
- R10: With the phit outputs looped back to the phit inputs, `rx_flit_o` equals the accepted flit, valid six cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_flit_i | input | 70 | Flit offered for transmission |
| tx_valid_i | input | 1 | Offered flit is valid |
| tx_ready_o | output | 1 | Transmitter takes a flit this cycle |
| tx_phit_o | output | 14 | Outgoing phit |
| tx_phit_vld_o | output | 1 | Outgoing phit is valid |
| tx_phit_sop_o | output | 1 | Outgoing phit is phit 0 of a flit |
| rx_phit_i | input | 14 | Incoming phit |
| rx_phit_vld_i | input | 1 | Incoming phit is valid |
| rx_phit_sop_i | input | 1 | Incoming phit is phit 0 of a flit |
| rx_flit_o | output | 70 | Rebuilt flit |
| rx_flit_vld_o | output | 1 | Rebuilt flit valid, one-cycle pulse |
| rx_len_err_o | output | 1 | Packet length error, set with a tail flit |

## Verification
The bench walks a single one through every data bit and the two spare control bits. A slice offset or a reversed phit order would show as a moved or missing bit. It offers a second flit while the first is still in flight. A transmitter that took it early would corrupt phits 1 to 4 or break the five-cycle back-to-back spacing. It sweeps short and long, read and write packets of 1 to 10 flits. An off-by-one in the word count, or a count that left out the head, would flag legal packets or pass bad ones. Direct receive tests cover orphan phits, gaps in valid, and a start marker in mid-flit. A receiver that kept partial slots, or that failed to resynchronise, would emit a spurious or mixed flit.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;
   // Control field bit offsets within the control slice of a flit
   localparam int unsigned CB_HEAD  = 0;
   localparam int unsigned CB_TAIL  = 1;
   localparam int unsigned CB_WRITE = 2;
   localparam int unsigned CB_LONG  = 3;
   localparam int unsigned CB_USED  = 4;
endpackage

// File: rtl/flit_tx_ser.sv
module flit_tx_ser #(
   parameter int unsigned PHIT_W  = 14,
   parameter int unsigned N_PHITS = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PHIT_W*N_PHITS-1:0]   flit_i,
   input  logic                        valid_i,
   output logic                        ready_o,
   output logic [PHIT_W-1:0]           phit_o,
   output logic                        vld_o,
   output logic                        sop_o
);
   localparam int unsigned FLIT_W = PHIT_W * N_PHITS;
   localparam int unsigned CNT_W  = (N_PHITS > 1) ? $clog2(N_PHITS) : 1;
   localparam int unsigned LAST   = N_PHITS - 1;

   logic [FLIT_W-1:0] hold_q;
   logic              busy_q;
   logic [CNT_W-1:0]  idx_q;
   logic              at_last;
   logic              take;
   logic [PHIT_W-1:0] slice [N_PHITS];

   assign at_last = busy_q && (idx_q == CNT_W'(LAST));
   assign ready_o = !busy_q || at_last;
   assign take    = valid_i && ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (take) begin
         hold_q <= flit_i;
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (at_last) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N_PHITS; g++) begin : g_slice
      assign slice[g] = hold_q[g*PHIT_W +: PHIT_W];
   end

   assign phit_o = busy_q ? slice[idx_q] : '0;
   assign vld_o  = busy_q;
   assign sop_o  = busy_q && (idx_q == '0);
endmodule

// File: rtl/flit_rx_deser.sv
module flit_rx_deser #(
   parameter int unsigned PHIT_W  = 14,
   parameter int unsigned N_PHITS = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PHIT_W-1:0]           phit_i,
   input  logic                        phit_vld_i,
   input  logic                        phit_sop_i,
   output logic [PHIT_W*N_PHITS-1:0]   asm_flit_o,
   output logic                        asm_vld_o
);
   localparam int unsigned CNT_W = (N_PHITS > 1) ? $clog2(N_PHITS) : 1;
   localparam int unsigned LAST  = N_PHITS - 1;

   logic              aligned_q;
   logic [CNT_W-1:0]  idx_q;
   logic [PHIT_W-1:0] slot_q [LAST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aligned_q <= 1'b0;
         idx_q     <= '0;
      end else if (phit_vld_i) begin
         if (phit_sop_i) begin
            aligned_q <= 1'b1;
            idx_q     <= CNT_W'(1);
         end else if (aligned_q) begin
            if (idx_q == CNT_W'(LAST)) begin
               aligned_q <= 1'b0;
               idx_q     <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < LAST; g++) begin : g_slot
      logic wr;
      assign wr = phit_vld_i &&
                  ((phit_sop_i && (g == 0)) ||
                   (!phit_sop_i && aligned_q && (idx_q == CNT_W'(g))));
      always_ff @(posedge clk) begin
         if (!rst_n)  slot_q[g] <= '0;
         else if (wr) slot_q[g] <= phit_i;
      end
      assign asm_flit_o[g*PHIT_W +: PHIT_W] = slot_q[g];
   end

   assign asm_flit_o[LAST*PHIT_W +: PHIT_W] = phit_i;
   assign asm_vld_o = phit_vld_i && !phit_sop_i && aligned_q &&
                      (idx_q == CNT_W'(LAST));
endmodule

// File: rtl/flit_pkt_check.sv
module flit_pkt_check #(
   parameter int unsigned SHORT_LEN = 1,
   parameter int unsigned LONG_LEN  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic head_i,
   input  logic tail_i,
   input  logic long_i,
   output logic err_o
);
   localparam int unsigned CW   = $clog2(LONG_LEN + 2);
   localparam int unsigned MAXC = (1 << CW) - 1;

   logic          open_q;
   logic          long_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic          eff_open;
   logic          eff_long;
   logic [CW-1:0] eff_cnt;
   logic [CW-1:0] want;

   assign cnt_inc  = (cnt_q == CW'(MAXC)) ? cnt_q : cnt_q + 1'b1;
   assign eff_open = head_i || open_q;
   assign eff_long = head_i ? long_i : long_q;
   assign eff_cnt  = head_i ? CW'(1) : (open_q ? cnt_inc : '0);
   assign want     = eff_long ? CW'(LONG_LEN) : CW'(SHORT_LEN);
   assign err_o    = vld_i && tail_i && (!eff_open || (eff_cnt != want));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         long_q <= 1'b0;
         cnt_q  <= '0;
      end else if (vld_i) begin
         if (tail_i) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
         end else if (eff_open) begin
            open_q <= 1'b1;
            long_q <= eff_long;
            cnt_q  <= eff_cnt;
         end
      end
   end
endmodule

// File: rtl/flit_link_serdes.sv
module flit_link_serdes
   import flit_link_pkg::*;
#(
   parameter int unsigned PHIT_W    = 14,
   parameter int unsigned N_PHITS   = 5,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned CTRL_W    = 6,
   parameter int unsigned SHORT_LEN = 1,
   parameter int unsigned LONG_LEN  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DATA_W+CTRL_W-1:0]    tx_flit_i,
   input  logic                        tx_valid_i,
   output logic                        tx_ready_o,
   output logic [PHIT_W-1:0]           tx_phit_o,
   output logic                        tx_phit_vld_o,
   output logic                        tx_phit_sop_o,
   input  logic [PHIT_W-1:0]           rx_phit_i,
   input  logic                        rx_phit_vld_i,
   input  logic                        rx_phit_sop_i,
   output logic [DATA_W+CTRL_W-1:0]    rx_flit_o,
   output logic                        rx_flit_vld_o,
   output logic                        rx_len_err_o
);
   localparam int unsigned FLIT_W = DATA_W + CTRL_W;

   if (PHIT_W * N_PHITS != FLIT_W) begin : g_bad_split
      $error("phit width times phit count must equal flit width");
   end
   if (N_PHITS < 2) begin : g_bad_count
      $error("at least two phits per flit are needed");
   end
   if (CTRL_W < CB_USED) begin : g_bad_ctrl
      $error("control field too narrow for framing bits");
   end
   if (SHORT_LEN < 1 || LONG_LEN < 1) begin : g_bad_len
      $error("packet lengths must be at least one word");
   end

   logic [FLIT_W-1:0] asm_flit;
   logic              asm_vld;
   logic              len_err;

   flit_tx_ser #(.PHIT_W(PHIT_W), .N_PHITS(N_PHITS)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .flit_i  (tx_flit_i),
      .valid_i (tx_valid_i),
      .ready_o (tx_ready_o),
      .phit_o  (tx_phit_o),
      .vld_o   (tx_phit_vld_o),
      .sop_o   (tx_phit_sop_o)
   );

   flit_rx_deser #(.PHIT_W(PHIT_W), .N_PHITS(N_PHITS)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .phit_i     (rx_phit_i),
      .phit_vld_i (rx_phit_vld_i),
      .phit_sop_i (rx_phit_sop_i),
      .asm_flit_o (asm_flit),
      .asm_vld_o  (asm_vld)
   );

   flit_pkt_check #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_pkt (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (asm_vld),
      .head_i (asm_flit[DATA_W + CB_HEAD]),
      .tail_i (asm_flit[DATA_W + CB_TAIL]),
      .long_i (asm_flit[DATA_W + CB_LONG]),
      .err_o  (len_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_flit_o     <= '0;
         rx_flit_vld_o <= 1'b0;
         rx_len_err_o  <= 1'b0;
      end else begin
         rx_flit_vld_o <= asm_vld;
         rx_len_err_o  <= len_err;
         if (asm_vld) rx_flit_o <= asm_flit;
      end
   end
endmodule

// File: rtl/flit_link_chk.sv
module flit_link_chk #(
   parameter int unsigned PHIT_W  = 14,
   parameter int unsigned N_PHITS = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [PHIT_W-1:0] first_phit_i,
   input logic              tx_valid_i,
   input logic              tx_ready_o,
   input logic [PHIT_W-1:0] tx_phit_o,
   input logic              tx_phit_vld_o,
   input logic              tx_phit_sop_o,
   input logic              rx_flit_vld_o,
   input logic              rx_len_err_o
);
   localparam int unsigned PCW = $clog2(N_PHITS + 1);

   logic [PCW-1:0] ph_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             ph_cnt_q <= '0;
      else if (tx_phit_vld_o) ph_cnt_q <= tx_phit_sop_o ? PCW'(1) : ph_cnt_q + 1'b1;
   end

   AST_ACCEPT_SOP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o) |=> tx_phit_sop_o);                            // R3
   AST_FIRST_PHIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_i && tx_ready_o) |=> (tx_phit_o == $past(first_phit_i)));       // R2
   AST_SOP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tx_phit_sop_o |-> tx_phit_vld_o);                                         // R3
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_phit_vld_o |-> tx_ready_o);                                           // R4
   AST_NO_OVERLONG: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_phit_vld_o && !tx_phit_sop_o) |-> (ph_cnt_q != '0 && ph_cnt_q < PCW'(N_PHITS))); // R2
   AST_FULL_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_phit_sop_o && ph_cnt_q != '0) |-> (ph_cnt_q == PCW'(N_PHITS)));      // R2
   AST_FLIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flit_vld_o |=> !rx_flit_vld_o);                                        // R5
   AST_ERR_WITH_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_len_err_o |-> rx_flit_vld_o);                                          // R8
endmodule

bind flit_link_serdes flit_link_chk #(.PHIT_W(PHIT_W), .N_PHITS(N_PHITS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .first_phit_i  (tx_flit_i[PHIT_W-1:0]),
   .tx_valid_i    (tx_valid_i),
   .tx_ready_o    (tx_ready_o),
   .tx_phit_o     (tx_phit_o),
   .tx_phit_vld_o (tx_phit_vld_o),
   .tx_phit_sop_o (tx_phit_sop_o),
   .rx_flit_vld_o (rx_flit_vld_o),
   .rx_len_err_o  (rx_len_err_o)
);

// File: tb/sim_flit_link_serdes.sv
`timescale 1ns/1ps
module sim_flit_link_serdes;
   localparam int PW = 14;
   localparam int NP = 5;
   localparam int FW = 70;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] tx_flit = '0;
   logic          tx_valid = 1'b0;
   logic          tx_ready;
   logic [PW-1:0] tx_phit;
   logic          tx_vld, tx_sop;
   logic [PW-1:0] rx_phit, bp = '0;
   logic          rx_vld, rx_sop, bv = 1'b0, bs = 1'b0;
   logic          lb = 1'b1;
   logic [FW-1:0] rx_flit;
   logic          rx_fv, rx_err;
   int            n_chk = 0;
   int            n_err = 0;

   always #10 clk = ~clk;

   assign rx_phit = lb ? tx_phit : bp;
   assign rx_vld  = lb ? tx_vld  : bv;
   assign rx_sop  = lb ? tx_sop  : bs;

   flit_link_serdes u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_flit_i(tx_flit), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
      .tx_phit_o(tx_phit), .tx_phit_vld_o(tx_vld), .tx_phit_sop_o(tx_sop),
      .rx_phit_i(rx_phit), .rx_phit_vld_i(rx_vld), .rx_phit_sop_i(rx_sop),
      .rx_flit_o(rx_flit), .rx_flit_vld_o(rx_fv), .rx_len_err_o(rx_err)
   );

   task automatic chk(input bit ok, input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   function automatic logic [63:0] data_of(input int i);
      return {32'(i) * 32'h9E3779B9, ~(32'(i) * 32'h85EBCA6B)};
   endfunction

   // one flit through the loopback: phits at k=1..5, rebuilt flit at k=6
   task automatic xmit(input logic [FW-1:0] f, input logic exp_err, input string tag);
      @(negedge clk);
      chk(tx_ready == 1'b1, "R4 ready while idle", FW'(tx_ready), 1);
      tx_flit = f;
      tx_valid = 1'b1;
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         if (k == 1) tx_valid = 1'b0;
         if (k <= 5) begin
            chk(tx_phit == f[(k-1)*PW +: PW] && tx_vld, "R2 phit order", FW'(tx_phit), FW'(f[(k-1)*PW +: PW]));
            chk(tx_sop == (k == 1), "R3 start marker", FW'(tx_sop), FW'(k == 1));
            chk(tx_ready == (k == 5), "R4 ready timing", FW'(tx_ready), FW'(k == 5));
            chk(rx_fv == 1'b0, "R5 no early flit", FW'(rx_fv), 0);
         end else begin
            chk(rx_fv == 1'b1, "R10 flit valid", FW'(rx_fv), 1);
            chk(rx_flit == f, "R10 flit equal", rx_flit, f);
            chk(rx_err == exp_err, tag, FW'(rx_err), FW'(exp_err));
         end
      end
   endtask

   task automatic rx_feed(input logic [PW-1:0] p, input bit sop, input bit vld, input bit exp_fv, input string tag);
      @(negedge clk);
      chk(rx_fv == exp_fv, tag, FW'(rx_fv), FW'(exp_fv));
      bp = p;
      bs = sop;
      bv = vld;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [FW-1:0] fa, fb, fexp;
      logic [PW-1:0] p [NP];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_ready == 1'b1, "R1 ready", FW'(tx_ready), 1);
      chk(tx_vld == 1'b0 && tx_sop == 1'b0, "R1 phit idle", FW'({tx_vld, tx_sop}), 0);
      chk(rx_fv == 1'b0 && rx_err == 1'b0, "R1 rx idle", FW'({rx_fv, rx_err}), 0);

      // R2 walking one over data bits and spare control bits 68,69 (R7)
      for (int b = 0; b < FW; b++) begin
         if (b < 64 || b >= 68) xmit(FW'(1) << b, 1'b0, "R7 spare bits no error");
      end
      for (int i = 0; i < 8; i++) xmit({6'b0, data_of(i)}, 1'b0, "R9 stray body ignored");

      // R4 back to back with a flit offered while not ready
      fa = {6'b0, data_of(100)};
      fb = {6'b0, data_of(101)};
      @(negedge clk);
      tx_flit = fa;
      tx_valid = 1'b1;
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         if (k == 1) tx_flit = fb;
         if (k <= 5) begin
            chk(tx_phit == fa[(k-1)*PW +: PW], "R4 busy offer ignored", FW'(tx_phit), FW'(fa[(k-1)*PW +: PW]));
            chk(tx_ready == (k == 5), "R4 ready only on last phit", FW'(tx_ready), FW'(k == 5));
         end else if (k <= 10) begin
            if (k == 6) tx_valid = 1'b0;
            chk(tx_phit == fb[(k-6)*PW +: PW] && tx_vld, "R4 back to back phits", FW'(tx_phit), FW'(fb[(k-6)*PW +: PW]));
            chk(tx_sop == (k == 6), "R3 second marker", FW'(tx_sop), FW'(k == 6));
         end
         if (k == 6) chk(rx_fv && rx_flit == fa, "R10 first flit", rx_flit, fa);
         if (k == 11) chk(rx_fv && rx_flit == fb, "R10 second flit", rx_flit, fb);
      end

      // R8 packet sweep: long/short x read/write x 1..10 flits
      for (int lg = 0; lg < 2; lg++)
         for (int wr = 0; wr < 2; wr++)
            for (int n = 1; n <= 10; n++)
               for (int i = 0; i < n; i++) begin
                  logic [5:0] c;
                  bit last;
                  last = (i == n - 1);
                  c = {2'(i), 1'(lg), 1'(wr), 1'(last), 1'(i == 0)};
                  xmit({c, data_of(n * 16 + i)}, last && (n != (lg ? 8 : 1)), "R8 length check");
               end

      // R9 tail with no open packet, body with no open packet
      xmit({6'b000010, data_of(7)}, 1'b1, "R9 orphan tail");
      xmit({6'b000000, data_of(8)}, 1'b0, "R9 stray body");
      xmit({6'b000010, data_of(9)}, 1'b1, "R9 tail after stray body");
      // R8 a new head restarts the count
      xmit({6'b001001, data_of(10)}, 1'b0, "R8 long head");
      for (int i = 0; i < 3; i++) xmit({6'b000000, data_of(11 + i)}, 1'b0, "R8 body");
      xmit({6'b000011, data_of(20)}, 1'b0, "R8 restart short single");

      // direct receive tests
      lb = 1'b0;
      for (int i = 0; i < 3; i++) rx_feed(14'h3FFF, 1'b0, 1'b1, 1'b0, "R6 orphan phit");
      rx_feed('0, 1'b0, 1'b0, 1'b0, "R6 orphan phit");
      rx_feed('0, 1'b0, 1'b0, 1'b0, "R6 orphan dropped");
      for (int i = 0; i < NP; i++) p[i] = 14'h0050 + 14'(i);
      rx_feed(p[0], 1'b1, 1'b1, 1'b0, "R5 gap");
      rx_feed('0,   1'b0, 1'b0, 1'b0, "R5 gap");
      rx_feed(p[1], 1'b0, 1'b1, 1'b0, "R5 gap");
      rx_feed(p[2], 1'b0, 1'b1, 1'b0, "R5 gap");
      rx_feed('0,   1'b0, 1'b0, 1'b0, "R5 gap");
      rx_feed(p[3], 1'b0, 1'b1, 1'b0, "R5 gap");
      rx_feed(p[4], 1'b0, 1'b1, 1'b0, "R5 gap");
      rx_feed('0,   1'b0, 1'b0, 1'b1, "R5 flit after gaps");
      fexp = {p[4], p[3], p[2], p[1], p[0]};
      chk(rx_flit == fexp, "R5 slot order", rx_flit, fexp);
      rx_feed(14'h0011, 1'b1, 1'b1, 1'b0, "R6 restart");
      rx_feed(14'h0012, 1'b0, 1'b1, 1'b0, "R6 restart");
      rx_feed(14'h0013, 1'b0, 1'b1, 1'b0, "R6 restart");
      for (int i = 0; i < NP; i++) p[i] = 14'h0070 + 14'(i);
      rx_feed(p[0], 1'b1, 1'b1, 1'b0, "R6 restart");
      for (int i = 1; i < NP; i++) rx_feed(p[i], 1'b0, 1'b1, 1'b0, "R6 restart");
      rx_feed('0, 1'b0, 1'b0, 1'b1, "R6 flit after restart");
      fexp = {p[4], p[3], p[2], p[1], p[0]};
      chk(rx_flit == fexp, "R6 partial discarded", rx_flit, fexp);
      chk(rx_err == 1'b0, "R9 body no error", FW'(rx_err), 0);
      for (int i = 0; i < NP; i++) rx_feed(14'h0001, 1'b0, 1'b1, 1'b0, "R6 unaligned dropped");
      rx_feed('0, 1'b0, 1'b0, 1'b0, "R6 unaligned dropped");
      rx_feed('0, 1'b0, 1'b0, 1'b0, "R6 unaligned dropped");

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule